// File: doc/BRIEF.md
# Parallel NOR Flash Page-Mode Reader

This block pulls a linear run of words out of an asynchronous parallel NOR flash and hands them to the chip on a valid/ready stream. After a start request it drives the flash address and holds chip enable and output enable low until the last word is accepted. Each word is captured after an access time and loaded into a holding register that feeds the stream. The access time depends on where the word falls in a flash page. The first word of a run, and the first word of every page, waits a configurable number of clock cycles. Every other word of the same page is captured one cycle after its address changes.

Page size, first-access latency and bus width come from static configuration inputs and are sampled when a run starts. On the external bus, line 0 carries the most significant bit. Each captured word is therefore bit-reversed into normal internal significance. In the 8-bit bus mode only lines 0 to 7 are used and the result fills the low byte. A page size of one word allows only a one-cycle first access. Any other latency with that page size raises a configuration error and is overridden to one cycle.

Top module: `nor_page_reader`

## Requirements
- R1: A start pulse while idle reads `word_count` words from consecutive addresses beginning at `start_addr`. `done` is high for exactly one cycle, the cycle after the last word is accepted. A start with `word_count` of 0 gives `done` in the next cycle and makes no flash access.
- R2: `cfg_page_sel` sets the page size: 2'b00 is 1 word, 2'b01 is 4 words, and 2'b10 or 2'b11 is 8 words. Code 2'b11 is used for flashes with larger physical pages. A new page starts at each address whose low page-offset bits are zero.
- R3: `cfg_first_lat` code 0 to 3 selects a first-access latency L of 1 to 4 cycles. The first word of a run, and the first word of each page, is captured L clock edges after its address appears. `out_valid` rises on that same edge.
- R4: A word that is not the first of its page is captured on the clock edge one cycle after its address appears.
- R5: With page size 1 and a nonzero `cfg_first_lat`, `cfg_err` is high and one-cycle latency is used. `cfg_err` is low for every other combination.
- R6: In 16-bit mode (`cfg_wide` = 1), `out_data[15-i]` equals `flash_dq[i]` for i = 0 to 15.
- R7: In 8-bit mode (`cfg_wide` = 0), `out_data[7-i]` equals `flash_dq[i]` for i = 0 to 7. `out_data[15:8]` is zero, and `flash_dq[15:8]` has no effect.
- R8: While `out_valid` is high and `out_ready` is low, `out_data`, `out_valid` and `flash_addr` stay unchanged.
- R9: `flash_ce_n` and `flash_oe_n` are low together from the first address of a run until its last word is accepted. Both are high when idle and during reset.
- R10: A start pulse during a run is ignored: the run's word stream is unchanged and no extra run follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Starts a run when idle |
| start_addr | input | AW | First word address of a run |
| word_count | input | CW | Number of words in a run |
| cfg_page_sel | input | 2 | Page size code |
| cfg_first_lat | input | 2 | First-access latency code (cycles minus one) |
| cfg_wide | input | 1 | 1 = 16-bit bus, 0 = 8-bit bus |
| cfg_err | output | 1 | Illegal page size and latency combination |
| flash_addr | output | AW | Flash word address |
| flash_ce_n | output | 1 | Flash chip enable, active low |
| flash_oe_n | output | 1 | Flash output enable, active low |
| flash_dq | input | DW | Flash data lines, line 0 most significant |
| out_data | output | DW | Reordered word |
| out_valid | output | 1 | Word available |
| out_ready | input | 1 | Consumer accepts word |
| done | output | 1 | One-cycle pulse after the last word |

## Verification
A flash model drives wrong data until an address has been held for the access time the requirements allow. Early capture therefore shows up as a data mismatch. At full rate, the spacing between accepted words exposes late capture and tells first-of-page words from in-page words. Runs cover each page size and latency code. They include starts in the middle of a page that cross page boundaries, both bus widths, and the illegal one-word-page combination. Runs with random `out_ready` stalls check that held words and addresses do not move. A second start pulse in the middle of a run shows that it neither changes the stream nor adds a run.

// File: rtl/nor_rd_pkg.sv
package nor_rd_pkg;

    localparam int LAT_W  = 3;
    localparam int OFS_W  = 3;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_HOLD = 2'd2
    } rd_state_e;

    typedef struct packed {
        logic [OFS_W-1:0] pmask;
        logic [LAT_W-1:0] lat;
        logic             err;
    } rd_cfg_t;

endpackage

// File: rtl/nor_rd_cfg.sv
module nor_rd_cfg
    import nor_rd_pkg::*;
(
    input  logic [1:0] page_sel,
    input  logic [1:0] lat_code,
    output rd_cfg_t    cfg
);
    logic [LAT_W-1:0] lat_raw;
    logic             single;

    always_comb begin
        single  = 1'b0;
        cfg     = '0;
        lat_raw = LAT_W'(lat_code) + LAT_W'(1);
        case (page_sel)
            2'b00:   begin cfg.pmask = 3'b000; single = 1'b1; end
            2'b01:   cfg.pmask = 3'b011;
            default: cfg.pmask = 3'b111;
        endcase
        cfg.err = single && (lat_code != 2'b00);
        cfg.lat = single ? LAT_W'(1) : lat_raw;
    end
endmodule

// File: rtl/nor_rd_order.sv
module nor_rd_order #(
    parameter int DW = 16
) (
    input  logic          wide,
    input  logic [DW-1:0] dq,
    output logic [DW-1:0] word
);
    localparam int NW = DW / 2;

    logic [DW-1:0] full_rev;
    logic [NW-1:0] half_rev;

    genvar i;
    generate
        for (i = 0; i < DW; i++) begin : g_full
            assign full_rev[DW-1-i] = dq[i];
        end
        for (i = 0; i < NW; i++) begin : g_half
            assign half_rev[NW-1-i] = dq[i];
        end
    endgenerate

    always_comb begin
        if (wide) word = full_rev;
        else      word = {{(DW-NW){1'b0}}, half_rev};
    end
endmodule

// File: rtl/nor_rd_seq.sv
module nor_rd_seq
    import nor_rd_pkg::*;
#(
    parameter int AW = 24,
    parameter int CW = 16,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] start_addr,
    input  logic [CW-1:0] word_count,
    input  rd_cfg_t       cfg,
    input  logic          cfg_wide,
    input  logic [DW-1:0] rd_word,
    input  logic          out_ready,
    output logic [AW-1:0] addr,
    output logic          active,
    output logic          wide,
    output logic [DW-1:0] data,
    output logic          valid,
    output logic          done
);
    typedef struct packed {
        rd_state_e        state;
        logic [AW-1:0]    addr;
        logic [CW-1:0]    remain;
        logic [LAT_W-1:0] cnt;
        logic [OFS_W-1:0] pmask;
        logic [LAT_W-1:0] lat;
        logic             wide;
        logic [DW-1:0]    data;
        logic             valid;
        logic             done;
    } seq_t;

    localparam logic [AW-1:0] ADDR_ONE = {{(AW-1){1'b0}}, 1'b1};
    localparam logic [CW-1:0] CNT_ONE  = {{(CW-1){1'b0}}, 1'b1};

    seq_t q, d;
    logic [AW-1:0] addr_nx;
    logic          page_start;

    always_comb begin
        d          = q;
        d.done     = 1'b0;
        addr_nx    = q.addr + ADDR_ONE;
        page_start = ((addr_nx & {{(AW-OFS_W){1'b0}}, q.pmask}) == '0);
        case (q.state)
            ST_IDLE: begin
                if (start) begin
                    d.pmask = cfg.pmask;
                    d.lat   = cfg.lat;
                    d.wide  = cfg_wide;
                    if (word_count == '0) begin
                        d.done = 1'b1;
                    end else begin
                        d.state  = ST_WAIT;
                        d.addr   = start_addr;
                        d.remain = word_count;
                        d.cnt    = cfg.lat;
                    end
                end
            end
            ST_WAIT: begin
                if (q.cnt <= LAT_W'(1)) begin
                    d.data  = rd_word;
                    d.valid = 1'b1;
                    d.state = ST_HOLD;
                end else begin
                    d.cnt = q.cnt - LAT_W'(1);
                end
            end
            ST_HOLD: begin
                if (out_ready) begin
                    d.valid = 1'b0;
                    if (q.remain == CNT_ONE) begin
                        d.state = ST_IDLE;
                        d.done  = 1'b1;
                    end else begin
                        d.addr   = addr_nx;
                        d.remain = q.remain - CNT_ONE;
                        d.cnt    = page_start ? q.lat : LAT_W'(1);
                        d.state  = ST_WAIT;
                    end
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= ST_IDLE;
            q.lat   <= LAT_W'(1);
            q.wide  <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign addr   = q.addr;
    assign active = (q.state != ST_IDLE);
    assign wide   = q.wide;
    assign data   = q.data;
    assign valid  = q.valid;
    assign done   = q.done;
endmodule

// File: rtl/nor_page_reader.sv
module nor_page_reader
    import nor_rd_pkg::*;
#(
    parameter int AW = 24,
    parameter int CW = 16,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] start_addr,
    input  logic [CW-1:0] word_count,
    input  logic [1:0]    cfg_page_sel,
    input  logic [1:0]    cfg_first_lat,
    input  logic          cfg_wide,
    output logic          cfg_err,
    output logic [AW-1:0] flash_addr,
    output logic          flash_ce_n,
    output logic          flash_oe_n,
    input  logic [DW-1:0] flash_dq,
    output logic [DW-1:0] out_data,
    output logic          out_valid,
    input  logic          out_ready,
    output logic          done
);
    rd_cfg_t       cfg;
    logic [DW-1:0] rd_word;
    logic          active;
    logic          wide_q;

    nor_rd_cfg u_cfg (
        .page_sel (cfg_page_sel),
        .lat_code (cfg_first_lat),
        .cfg      (cfg)
    );

    nor_rd_order #(.DW(DW)) u_order (
        .wide (wide_q),
        .dq   (flash_dq),
        .word (rd_word)
    );

    nor_rd_seq #(.AW(AW), .CW(CW), .DW(DW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .start_addr (start_addr),
        .word_count (word_count),
        .cfg        (cfg),
        .cfg_wide   (cfg_wide),
        .rd_word    (rd_word),
        .out_ready  (out_ready),
        .addr       (flash_addr),
        .active     (active),
        .wide       (wide_q),
        .data       (out_data),
        .valid      (out_valid),
        .done       (done)
    );

    assign cfg_err    = cfg.err;
    assign flash_ce_n = !active;
    assign flash_oe_n = !active;
endmodule

// File: rtl/nor_page_reader_chk.sv
module nor_page_reader_chk #(
    parameter int AW = 24,
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic [1:0]    cfg_page_sel,
    input logic          cfg_wide,
    input logic          cfg_err,
    input logic [AW-1:0] flash_addr,
    input logic          flash_ce_n,
    input logic          flash_oe_n,
    input logic [DW-1:0] out_data,
    input logic          out_valid,
    input logic          out_ready,
    input logic          done
);
    localparam logic [AW-1:0] STEP = {{(AW-1){1'b0}}, 1'b1};

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R1

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready) |=> (done || (flash_addr == $past(flash_addr) + STEP))); // R1

    AST_ERR_ONE_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> (cfg_page_sel == 2'b00)); // R5

    AST_NARROW_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !cfg_wide) |-> (out_data[DW-1:DW/2] == '0)); // R7

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(flash_addr))); // R8

    AST_ENABLES_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
        flash_ce_n == flash_oe_n); // R9

    AST_VALID_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !flash_ce_n); // R9
endmodule

bind nor_page_reader nor_page_reader_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_page_sel (cfg_page_sel),
    .cfg_wide     (cfg_wide),
    .cfg_err      (cfg_err),
    .flash_addr   (flash_addr),
    .flash_ce_n   (flash_ce_n),
    .flash_oe_n   (flash_oe_n),
    .out_data     (out_data),
    .out_valid    (out_valid),
    .out_ready    (out_ready),
    .done         (done)
);

// File: tb/nor_page_reader_tb_top.sv
`timescale 1ns/1ps
module nor_page_reader_tb_top;
    localparam int AW = 24;
    localparam int CW = 16;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] start_addr = '0;
    logic [CW-1:0] word_count = '0;
    logic [1:0]    cfg_page_sel = 2'b00;
    logic [1:0]    cfg_first_lat = 2'b00;
    logic          cfg_wide = 1'b1;
    logic          cfg_err;
    logic [AW-1:0] flash_addr;
    logic          flash_ce_n, flash_oe_n;
    logic [DW-1:0] flash_dq = '0;
    logic [DW-1:0] out_data;
    logic          out_valid;
    logic          out_ready = 1'b0;
    logic          done;

    always #2.5 clk = ~clk;

    nor_page_reader #(.AW(AW), .CW(CW), .DW(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .word_count(word_count), .cfg_page_sel(cfg_page_sel),
        .cfg_first_lat(cfg_first_lat), .cfg_wide(cfg_wide), .cfg_err(cfg_err),
        .flash_addr(flash_addr), .flash_ce_n(flash_ce_n), .flash_oe_n(flash_oe_n),
        .flash_dq(flash_dq), .out_data(out_data), .out_valid(out_valid),
        .out_ready(out_ready), .done(done)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int ev_cyc = 0;
    int chg_cyc = 0;
    logic [AW-1:0] last_addr = '1;
    int run_start = 0;
    int cur_p = 1;
    int cur_l = 1;
    bit cur_wide = 1'b1;
    bit stall_mode = 1'b0;
    bit expect_done = 1'b0;
    bit prev_stall = 1'b0;
    logic [DW-1:0] prev_data;
    logic [AW-1:0] prev_addr;
    logic [DW-1:0] exp_q[$];
    int gap_q[$];
    int tag_q[$];

    function automatic logic [15:0] mem_word(input logic [AW-1:0] a);
        return {a[7:0] ^ 8'hC3, a[15:8] + a[7:0] + 8'h11};
    endfunction

    function automatic logic [15:0] expect_word(input logic [15:0] m, input bit wide);
        logic [15:0] r;
        r = '0;
        if (wide) begin
            for (int i = 0; i < 16; i++) r[15-i] = m[i];
        end else begin
            for (int i = 0; i < 8; i++) r[7-i] = m[i];
        end
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // flash model: wrong data until the address has been held long enough
    always @(negedge clk) begin
        bit first;
        int need;
        if (flash_addr != last_addr) begin
            last_addr = flash_addr;
            chg_cyc   = cyc;
        end
        first = (int'(flash_addr) == run_start) || ((int'(flash_addr) % cur_p) == 0);
        need  = first ? cur_l : 1;
        flash_dq = ((cyc - chg_cyc) >= need - 1) ? mem_word(flash_addr) : ~mem_word(flash_addr);
    end

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_stall)
                check(out_valid && out_data == prev_data && flash_addr == prev_addr,
                      "R8 stall hold", {out_data, flash_addr}, {prev_data, prev_addr});
            if (expect_done) begin
                check(done == 1'b1, "R1 done after last word", done, 1);
                expect_done = 1'b0;
            end
            out_ready = stall_mode ? ($urandom_range(0, 2) != 0) : 1'b1;
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R1 unexpected word", out_data, 0);
                end else begin
                    logic [DW-1:0] e;
                    int g, t;
                    e = exp_q.pop_front();
                    g = gap_q.pop_front();
                    t = tag_q.pop_front();
                    check(out_data == e, cur_wide ? "R6 data order" : "R7 data order", out_data, e);
                    check(!flash_ce_n && !flash_oe_n, "R9 enables during run",
                          {flash_ce_n, flash_oe_n}, 0);
                    if (!stall_mode)
                        check(cyc - ev_cyc == g,
                              (t == 2) ? "R2 page start latency" :
                              (t == 3) ? "R3 first access latency" : "R4 in-page latency",
                              cyc - ev_cyc, g);
                    ev_cyc = cyc;
                    if (exp_q.size() == 0) expect_done = 1'b1;
                end
            end
            prev_stall = out_valid && !out_ready;
            prev_data  = out_data;
            prev_addr  = flash_addr;
        end
    end

    task automatic run(input int sa, input int cnt, input logic [1:0] sel,
                       input logic [1:0] latc, input bit wide, input bit stall, input bit ghost);
        int p, l;
        bit err_exp;
        @(negedge clk);
        p = (sel == 2'b00) ? 1 : (sel == 2'b01) ? 4 : 8;
        err_exp = (sel == 2'b00) && (latc != 2'b00);
        l = err_exp ? 1 : int'(latc) + 1;
        cfg_page_sel = sel; cfg_first_lat = latc; cfg_wide = wide;
        cur_p = p; cur_l = l; cur_wide = wide; run_start = sa; stall_mode = stall;
        for (int k = 0; k < cnt; k++) begin
            int a;
            a = sa + k;
            exp_q.push_back(expect_word(mem_word(AW'(a)), wide));
            gap_q.push_back((k == 0 || a % p == 0) ? l + 1 : 2);
            tag_q.push_back((k == 0) ? 3 : (a % p == 0) ? 2 : 4);
        end
        #0.1;
        check(cfg_err == err_exp, "R5 config error flag", cfg_err, err_exp);
        start_addr = AW'(sa); word_count = CW'(cnt); start = 1'b1; ev_cyc = cyc;
        @(negedge clk);
        start = 1'b0;
        if (cnt == 0) begin
            #0.1;
            check(done == 1'b1, "R1 zero count done", done, 1);
            check(flash_ce_n && flash_oe_n, "R1 zero count no access", {flash_ce_n, flash_oe_n}, 3);
            return;
        end
        if (ghost) begin
            repeat (3) @(negedge clk);
            start_addr = AW'(24'h00F000); word_count = CW'(1); start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        for (int t = 0; t < 3000 && !done; t++) @(negedge clk);
        #0.1;
        check(done == 1'b1, "R1 run completes", done, 1);
        check(exp_q.size() == 0, "R1 all words delivered", exp_q.size(), 0);
        check(flash_ce_n && flash_oe_n, "R9 enables released", {flash_ce_n, flash_oe_n}, 3);
        if (ghost) begin
            repeat (4) begin
                @(negedge clk);
                #0.1;
                check(flash_ce_n && !out_valid, "R10 mid-run start ignored",
                      {flash_ce_n, out_valid}, 2);
            end
        end
        stall_mode = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R1: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!out_valid && flash_ce_n && flash_oe_n && !done, "R9 reset state",
              {out_valid, flash_ce_n, flash_oe_n, done}, 4'b0110);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        run(24'h000010, 5,  2'b00, 2'b00, 1'b1, 1'b0, 1'b0);
        run(24'h000102, 9,  2'b01, 2'b10, 1'b1, 1'b0, 1'b0);
        run(24'h0003F5, 12, 2'b10, 2'b11, 1'b1, 1'b0, 1'b0);
        run(24'h0003A5, 12, 2'b10, 2'b11, 1'b1, 1'b1, 1'b0);
        run(24'h000020, 10, 2'b11, 2'b01, 1'b1, 1'b0, 1'b0);
        run(24'h000046, 7,  2'b01, 2'b01, 1'b0, 1'b0, 1'b0);
        run(24'h000081, 6,  2'b01, 2'b00, 1'b0, 1'b1, 1'b0);
        run(24'h000200, 3,  2'b00, 2'b11, 1'b1, 1'b0, 1'b0);
        run(24'h000300, 0,  2'b01, 2'b00, 1'b1, 1'b0, 1'b0);
        run(24'h000411, 6,  2'b10, 2'b01, 1'b1, 1'b1, 1'b1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule